// File: doc/BRIEF.md
# CAN Time Base with Frame Capture and Message Stamps

This block supplies the free-running time base that a CAN controller uses to mark its traffic. An up-counter advances on a slow tick. The tick comes from the controller clock through a fixed divide-by-six stage, followed by a prescaler whose value is set at an input. The counter holds at zero while the controller is disabled. It wraps silently to zero after its maximum value, and each wrap raises a sticky overflow flag with a maskable interrupt.

The count can be captured in two ways. For time-triggered operation, one sync register latches the count on a frame boundary when the time-triggered mode input is high. A select input decides whether that boundary is the start or the end of the frame. For message stamping, a small stamp memory keeps one count value per message object. A receive-done or transmit-done strobe writes the present count into the entry named by its object index. Software reads an entry back through a registered read port.

Top module: `can_stamp_timer`

## Requirements
- R1: While enabled, the count (CNT_W bits, 16 by default) rises by exactly one on each tick and passes from all ones to zero.
- R2: While `ctl_en` is 0 the count, the divide-by-six stage and the prescaler are held at zero. After `ctl_en` returns to 1, counting starts again from zero.
- R3: With prescaler value N on `presc`, the count reaches floor(K / (6·(N+1))) after K enabled clock edges. N = 0 gives one tick every 6 edges.
- R4: The edge that moves the count from all ones to zero sets `ovf_flag_o`. The flag stays set until an edge with `ovf_clr` = 1. If a wrap and a clear fall on the same edge, the flag stays set.
- R5: `irq_o` is registered and equals the new overflow flag ANDed with `tim_ie`, both taken at the same edge.
- R6: When `tt_mode` = 1, `sync_cap_o` takes the count of the cycle in which the selected event strobe is high. `sync_sel` = 0 selects `sof_evt` and `sync_sel` = 1 selects `eof_evt`. The other strobe is ignored. When `tt_mode` = 0, both strobes are ignored.
- R7: An `rx_ok` pulse writes the count of its cycle into the stamp entry `rx_obj`. A `tx_ok` pulse does the same into entry `tx_obj`. Entries 0..14 exist, and index 15 writes nothing.
- R8: When `rx_ok` and `tx_ok` pulse in the same cycle for different objects, both entries are written. When they name the same object, the receive write is the one applied.
- R9: `rd_stamp_o` shows entry `rd_obj` one edge after `rd_obj` is presented. Clearing `ctl_en` leaves the stamp entries and `sync_cap_o` unchanged.
- R10: Reset (synchronous, active high) clears the count, `ovf_flag_o`, `irq_o` and `sync_cap_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable; 0 holds the time base at zero |
| tt_mode | input | 1 | Time-triggered mode; enables the sync capture |
| sync_sel | input | 1 | 0: capture on start of frame, 1: on end of frame |
| sof_evt | input | 1 | Start-of-frame strobe |
| eof_evt | input | 1 | End-of-frame strobe |
| presc | input | 8 | Prescaler value N |
| tim_ie | input | 1 | Overflow interrupt enable |
| ovf_clr | input | 1 | Clears the overflow flag |
| rx_ok | input | 1 | Receive-done strobe |
| rx_obj | input | 4 | Object index of the receive stamp |
| tx_ok | input | 1 | Transmit-done strobe |
| tx_obj | input | 4 | Object index of the transmit stamp |
| rd_obj | input | 4 | Stamp read index |
| count_o | output | CNT_W | Present count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt request |
| sync_cap_o | output | CNT_W | Count latched on the selected frame event |
| rd_stamp_o | output | CNT_W | Stamp read data |

## Verification
The assertions assume that `presc` changes only while `ctl_en` is low. They also assume that event and status strobes are single-cycle pulses driven between clock edges. Under those conditions the tick spacing and the capture values follow directly from the edge count since enable. The stimulus respects this: it drops `ctl_en` before loading each new prescaler value and drives every input on the falling clock edge. The bench runs the counter at a reduced width so that several wraps fit in one run.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam int DIV_FACTOR = 6;
  localparam int DIV_W      = $clog2(DIV_FACTOR);

  typedef enum logic {
    SYNC_ON_START = 1'b0,
    SYNC_ON_END   = 1'b1
  } sync_pick_e;
endpackage

// File: rtl/cst_tick_gen.sv
module cst_tick_gen
  import cst_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PRE_W-1:0] presc,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_FACTOR - 1);

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic             div_pulse;

  assign div_pulse = en && (div_q == DIV_LAST);
  assign tick_o    = div_pulse && (pre_q >= presc);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= div_pulse ? '0 : div_q + 1'b1;
      if (div_pulse) pre_q <= tick_o ? '0 : pre_q + 1'b1;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R3
endmodule

// File: rtl/cst_counter.sv
module cst_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             ovf_clr,
  input  logic             tim_ie,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             irq_o
);
  logic wrap;
  logic ovf_next;

  assign wrap     = en && tick && (count_o == '1);
  assign ovf_next = wrap ? 1'b1 : (ovf_clr ? 1'b0 : ovf_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      ovf_o   <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (!en)       count_o <= '0;
      else if (tick) count_o <= count_o + 1'b1;
      ovf_o <= ovf_next;
      irq_o <= ovf_next && tim_ie;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && tick) |=> (count_o == CNT_W'($past(count_o) + 1'b1))); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !en |=> (count_o == '0)); // R2
  AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf_o); // R4
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ovf_o); // R5
endmodule

// File: rtl/cst_stamp_mem.sv
module cst_stamp_mem #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 15,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rx_ok,
  input  logic [IDX_W-1:0] rx_obj,
  input  logic             tx_ok,
  input  logic [IDX_W-1:0] tx_obj,
  input  logic [CNT_W-1:0] wdata,
  input  logic [IDX_W-1:0] rd_obj,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [CNT_W-1:0] mem [DEPTH];

  // Receive write is placed last so it overrides a transmit write to the same entry.
  always_ff @(posedge clk) begin
    if (tx_ok && tx_obj <= LAST_IDX) mem[tx_obj] <= wdata;
    if (rx_ok && rx_obj <= LAST_IDX) mem[rx_obj] <= wdata;
  end

  always_ff @(posedge clk) begin
    rd_data_o <= (rd_obj <= LAST_IDX) ? mem[rd_obj] : '0;
  end
endmodule

// File: rtl/can_stamp_timer.sv
module can_stamp_timer
  import cst_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter int OBJS  = 15,
  parameter int IDX_W = $clog2(OBJS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_en,
  input  logic             tt_mode,
  input  logic             sync_sel,
  input  logic             sof_evt,
  input  logic             eof_evt,
  input  logic [PRE_W-1:0] presc,
  input  logic             tim_ie,
  input  logic             ovf_clr,
  input  logic             rx_ok,
  input  logic [IDX_W-1:0] rx_obj,
  input  logic             tx_ok,
  input  logic [IDX_W-1:0] tx_obj,
  input  logic [IDX_W-1:0] rd_obj,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] sync_cap_o,
  output logic [CNT_W-1:0] rd_stamp_o
);
  logic       tick;
  logic       sync_hit;
  sync_pick_e pick;

  assign pick     = sync_pick_e'(sync_sel);
  assign sync_hit = tt_mode && ((pick == SYNC_ON_START) ? sof_evt : eof_evt);

  cst_tick_gen #(.PRE_W(PRE_W)) i_tick (
    .clk(clk), .rst(rst), .en(ctl_en), .presc(presc), .tick_o(tick)
  );

  cst_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .en(ctl_en), .tick(tick), .ovf_clr(ovf_clr),
    .tim_ie(tim_ie), .count_o(count_o), .ovf_o(ovf_flag_o), .irq_o(irq_o)
  );

  cst_stamp_mem #(.CNT_W(CNT_W), .DEPTH(OBJS), .IDX_W(IDX_W)) i_stamp (
    .clk(clk), .rx_ok(rx_ok), .rx_obj(rx_obj), .tx_ok(tx_ok), .tx_obj(tx_obj),
    .wdata(count_o), .rd_obj(rd_obj), .rd_data_o(rd_stamp_o)
  );

  always_ff @(posedge clk) begin
    if (rst)           sync_cap_o <= '0;
    else if (sync_hit) sync_cap_o <= count_o;
  end

  AST_SYNC_TAKES_COUNT: assert property (@(posedge clk) disable iff (rst)
    sync_hit |=> (sync_cap_o == $past(count_o))); // R6
  AST_SYNC_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
    !tt_mode |=> $stable(sync_cap_o)); // R6
endmodule

// File: tb/test_can_stamp_timer.sv
module test_can_stamp_timer;
  localparam int CW = 10;
  localparam int MOD = 1 << CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_en = 0, tt_mode = 0, sync_sel = 0, sof_evt = 0, eof_evt = 0;
  logic [7:0] presc = '0;
  logic tim_ie = 0, ovf_clr = 0, rx_ok = 0, tx_ok = 0;
  logic [3:0] rx_obj = '0, tx_obj = '0, rd_obj = '0;
  logic [CW-1:0] count_o, sync_cap_o, rd_stamp_o;
  logic ovf_flag_o, irq_o;

  int n_chk = 0, n_bad = 0, ne = 0;

  always #2.5 clk = ~clk;

  can_stamp_timer #(.CNT_W(CW)) i_can_stamp_timer (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .tt_mode(tt_mode), .sync_sel(sync_sel),
    .sof_evt(sof_evt), .eof_evt(eof_evt), .presc(presc), .tim_ie(tim_ie),
    .ovf_clr(ovf_clr), .rx_ok(rx_ok), .rx_obj(rx_obj), .tx_ok(tx_ok), .tx_obj(tx_obj),
    .rd_obj(rd_obj), .count_o(count_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o),
    .sync_cap_o(sync_cap_o), .rd_stamp_o(rd_stamp_o)
  );

  // {prescaler, enabled edges, expected count}
  localparam int unsigned VEC [0:5][0:2] = '{
    '{0, 6, 1}, '{0, 59, 9}, '{1, 24, 2}, '{3, 100, 4}, '{7, 480, 10}, '{2, 17, 0}};

  function automatic int exp_cnt(int edges, int p);
    return (edges / (6 * (p + 1))) % MOD;
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      ne = ctl_en ? ne + 1 : 0;
      @(negedge clk);
    end
  endtask

  task automatic restart(int p);
    ctl_en = 0;
    step(1);
    presc = 8'(p);
    ctl_en = 1;
  endtask

  task automatic read_obj(int idx, output int val);
    rd_obj = 4'(idx);
    step(1);
    val = int'(rd_stamp_o);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v, c3, c7, c2;
    @(negedge clk);
    step(2);
    rst = 0;
    // R10 reset state
    chk("R10 count", count_o, 0);
    chk("R10 ovf", ovf_flag_o, 0);
    chk("R10 irq", irq_o, 0);
    chk("R10 sync", sync_cap_o, 0);

    // R3 / R1: prescaler table
    for (int k = 0; k < 6; k++) begin
      restart(VEC[k][0]);
      step(VEC[k][1]);
      chk("R3 table count", count_o, VEC[k][2]);
    end

    // R2: disable holds zero, restart from zero
    ctl_en = 0;
    step(3);
    chk("R2 held zero", count_o, 0);
    restart(0);
    step(5);
    chk("R2 no tick before 6 edges", count_o, 0);
    step(1);
    chk("R2 first tick after restart", count_o, 1);

    // R6 sync capture
    restart(0);
    step(30);
    tt_mode = 1; sync_sel = 0; sof_evt = 1;
    v = exp_cnt(ne, 0);
    step(1); sof_evt = 0;
    chk("R6 start capture", sync_cap_o, v);
    step(7);
    eof_evt = 1; step(1); eof_evt = 0;
    chk("R6 end ignored when start selected", sync_cap_o, v);
    sync_sel = 1; eof_evt = 1;
    v = exp_cnt(ne, 0);
    step(1); eof_evt = 0;
    chk("R6 end capture", sync_cap_o, v);
    step(12);
    tt_mode = 0; eof_evt = 1; sof_evt = 1; step(1); eof_evt = 0; sof_evt = 0;
    chk("R6 mode off ignored", sync_cap_o, v);

    // R7 / R8 stamps
    step(6);
    rx_ok = 1; rx_obj = 3; c3 = exp_cnt(ne, 0);
    step(1); rx_ok = 0;
    step(13);
    rx_ok = 1; rx_obj = 2; tx_ok = 1; tx_obj = 7; c2 = exp_cnt(ne, 0); c7 = c2;
    step(1); rx_ok = 0; tx_ok = 0;
    step(20);
    rx_ok = 1; rx_obj = 15; tx_ok = 1; tx_obj = 15; step(1); rx_ok = 0; tx_ok = 0;
    read_obj(3, v); chk("R7 receive stamp obj3", v, c3);
    read_obj(2, v); chk("R8 dual receive obj2", v, c2);
    read_obj(7, v); chk("R8 dual transmit obj7", v, c7);
    step(6);
    rx_ok = 1; tx_ok = 1; rx_obj = 5; tx_obj = 5; v = exp_cnt(ne, 0);
    step(1); rx_ok = 0; tx_ok = 0;
    read_obj(5, c2); chk("R8 same object", c2, v);

    // R9 retention across disable
    v = int'(sync_cap_o);
    ctl_en = 0; step(2);
    read_obj(3, c2); chk("R9 stamp kept", c2, c3);
    chk("R9 sync kept", sync_cap_o, v);
    chk("R9 count cleared", count_o, 0);

    // R4 / R5 overflow
    restart(0);
    tim_ie = 1;
    step(6 * MOD - 1);
    chk("R4 no flag before wrap", ovf_flag_o, 0);
    step(1);
    chk("R1 wrapped to zero", count_o, 0);
    chk("R4 flag on wrap", ovf_flag_o, 1);
    chk("R5 irq enabled", irq_o, 1);
    ovf_clr = 1; step(1); ovf_clr = 0;
    chk("R4 cleared", ovf_flag_o, 0);
    chk("R5 irq cleared", irq_o, 0);
    tim_ie = 0;
    step(12 * MOD - ne);
    chk("R4 second wrap", ovf_flag_o, 1);
    chk("R5 irq masked", irq_o, 0);
    step(18 * MOD - 2 - ne);
    ovf_clr = 1;
    step(1);
    chk("R4 clear before wrap", ovf_flag_o, 0);
    step(1);
    ovf_clr = 0;
    chk("R4 wrap beats clear", ovf_flag_o, 1);

    finish_run();
  end
endmodule